// File: doc/BRIEF.md
# Exception Entry Sequencer

This block performs the multi-cycle entry into an exception for a small 16-bit processor core. The core supplies a start strobe, the vector number of the exception it has already chosen, a flag that marks a reset entry, and the current program counter, status word and supervisor stack pointer. On start the sequencer keeps a snapshot of the status word. It then switches the live status word to supervisor mode with tracing off. It stacks the return address and then the snapshot on the supervisor stack, fetches the handler address from the vector table and hands back the new program counter, status word and stack pointer.

A reset entry trusts nothing from the interrupted context. It writes nothing to the stack and raises the interrupt mask to its highest level. It loads the stack pointer from the longword at address 0 and the program counter from the longword at address 4, so the reset vector spans two table slots. Memory traffic goes through one write port and one read port. Each port uses a valid/ready handshake, and the sequencer waits in place for as long as ready stays low.

Top module: `exc_entry_seq`

## Requirements
- R1: After a synchronous active-low reset, busy_o, done_o, wr_valid_o and rd_valid_o are all 0.
- R2: For a normal entry, the status word output equals the input status word with bit 13 (supervisor) set to 1, bit 15 (trace) cleared to 0, and every other bit unchanged.
- R3: A normal entry first writes the program counter as a longword (wr_long_o = 1) at address SSP - 4.
- R4: The second write of a normal entry is a word (wr_long_o = 0) at address SSP - 6. Its data is the status word as it was before any change, zero-extended, and the stack pointer output then equals SSP - 6.
- R5: A normal entry reads the vector table once, at address vector number * 4, and the program counter output becomes the longword returned by that read.
- R6: A reset entry performs no write. It reads address 0 into the stack pointer output and then address 4 into the program counter output. Its status word output has bits 10..8 (interrupt mask) set to 111, bit 13 set and bit 15 cleared.
- R7: done_o is high for exactly one cycle, in the cycle after the final read is accepted, and busy_o is low in the cycle after that.
- R8: A start request seen while busy is ignored, and changes to the context inputs while busy do not affect the result.
- R9: While a valid is high and its ready is low, the valid stays high and the address, data and size stay unchanged.
- R10: The write port and the read port are never valid in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request to begin an exception entry |
| reset_entry_i | input | 1 | Marks the request as a reset entry |
| vec_num_i | input | VEC_W | Vector number of the exception |
| pc_i | input | AW | Return program counter |
| sr_i | input | 16 | Current status word |
| ssp_i | input | AW | Current supervisor stack pointer |
| wr_valid_o | output | 1 | Write request valid |
| wr_ready_i | input | 1 | Write request accepted |
| wr_addr_o | output | AW | Write byte address |
| wr_data_o | output | AW | Write data, right-aligned for word writes |
| wr_long_o | output | 1 | 1 = longword write, 0 = word write |
| rd_valid_o | output | 1 | Read request valid |
| rd_ready_i | input | 1 | Read accepted, rd_data_i valid |
| rd_addr_o | output | AW | Read byte address |
| rd_data_i | input | AW | Longword read data |
| busy_o | output | 1 | Entry in progress |
| done_o | output | 1 | One-cycle completion pulse |
| pc_o | output | AW | New program counter |
| sr_o | output | 16 | Live status word |
| ssp_o | output | AW | Updated supervisor stack pointer |

## Verification
The bench sweeps every vector number from 2 to 255, with memory wait states varying from zero to three and with status words whose trace and supervisor bits take every combination. A design that stacked the modified status word instead of the snapshot would push a word with S already set and T already clear. Swapped push order or a wrong pre-decrement amount shows up as wrong addresses or wrong write sizes. Reset entries are driven with the same wait-state mix, where a design that wrote to the stack, forgot the mask or fetched the two longwords in the wrong order gives a wrong write count or a wrong stack pointer and program counter. Some runs hold start high and scramble the context inputs while busy, which catches a sequencer that restarts or reads its inputs late.

// File: rtl/exc_pkg.sv
// Shared definitions for the exception entry sequencer.
// Assumes a 16-bit status word with the trace, supervisor and
// interrupt-mask fields at the positions below.
package exc_pkg;

    localparam int SR_W        = 16;
    localparam int SR_T_BIT    = 15;
    localparam int SR_S_BIT    = 13;
    localparam int SR_MASK_LO  = 8;
    localparam int SR_MASK_W   = 3;
    localparam int LONG_BYTES  = 4;
    localparam int WORD_BYTES  = 2;
    localparam int RESET_PC_AT = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PUSH_PC,
        ST_PUSH_SR,
        ST_LOAD_SP,
        ST_LOAD_PC,
        ST_FINISH
    } exc_state_e;

endpackage

// File: rtl/exc_status_ctl.sv
// Status word unit: on capture it keeps an untouched snapshot of the
// incoming status word and forms the live word with supervisor on,
// trace off, and for reset the interrupt mask at its maximum.
// Assumes capture_i is a single-cycle strobe from the sequencer.
module exc_status_ctl
    import exc_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            capture_i,
    input  logic            reset_entry_i,
    input  logic [SR_W-1:0] sr_i,
    output logic [SR_W-1:0] sr_copy_o,
    output logic [SR_W-1:0] sr_live_o
);

    logic [SR_W-1:0] sr_mod;

    // Form the modified status word from the incoming one.
    always_comb begin
        sr_mod = sr_i;
        sr_mod[SR_S_BIT] = 1'b1;
        sr_mod[SR_T_BIT] = 1'b0;
        if (reset_entry_i) begin
            sr_mod[SR_MASK_LO +: SR_MASK_W] = '1;
        end
    end

    // Register the snapshot and the live word on capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_copy_o <= '0;
            sr_live_o <= '0;
        end else if (capture_i) begin
            sr_copy_o <= sr_i;
            sr_live_o <= sr_mod;
        end
    end

    a_r2_super_on_trace_off: assert property (@(posedge clk) disable iff (!rst_n)
        capture_i |=> (sr_live_o[SR_S_BIT] && !sr_live_o[SR_T_BIT]));

    a_r6_mask_raised: assert property (@(posedge clk) disable iff (!rst_n)
        (capture_i && reset_entry_i) |=> (sr_live_o[SR_MASK_LO +: SR_MASK_W] == '1));

    a_r4_copy_untouched: assert property (@(posedge clk) disable iff (!rst_n)
        capture_i |=> (sr_copy_o == $past(sr_i)));

endmodule

// File: rtl/exc_stack_ptr.sv
// Supervisor stack pointer register. It can be loaded with a new value
// or stepped down by a longword or a word. The pre-decremented
// addresses are offered combinationally so a push can use them
// before the step is committed.
// Assumes at most one of load/step is active in a cycle.
module exc_stack_ptr
    import exc_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [AW-1:0] load_val_i,
    input  logic          step_long_i,
    input  logic          step_word_i,
    output logic [AW-1:0] sp_o,
    output logic [AW-1:0] sp_minus_long_o,
    output logic [AW-1:0] sp_minus_word_o
);

    localparam logic [AW-1:0] LONG_STEP = AW'(LONG_BYTES);
    localparam logic [AW-1:0] WORD_STEP = AW'(WORD_BYTES);

    // Pre-decremented addresses for the next push.
    always_comb begin
        sp_minus_long_o = sp_o - LONG_STEP;
        sp_minus_word_o = sp_o - WORD_STEP;
    end

    // Stack pointer register update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp_o <= '0;
        end else if (load_i) begin
            sp_o <= load_val_i;
        end else if (step_long_i) begin
            sp_o <= sp_minus_long_o;
        end else if (step_word_i) begin
            sp_o <= sp_minus_word_o;
        end
    end

    a_r3_long_step: assert property (@(posedge clk) disable iff (!rst_n)
        (step_long_i && !load_i) |=> (sp_o == $past(sp_o) - LONG_STEP));

    a_r4_word_step: assert property (@(posedge clk) disable iff (!rst_n)
        (step_word_i && !load_i && !step_long_i) |=> (sp_o == $past(sp_o) - WORD_STEP));

endmodule

// File: rtl/exc_fsm.sv
// Sequencing state machine for exception entry. It accepts a start
// only when idle, then walks through the stack pushes (normal entry) or
// the stack pointer fetch (reset entry), then the vector fetch and a
// one-cycle completion state. Each memory step waits for its ready.
module exc_fsm
    import exc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic reset_entry_i,
    input  logic wr_ready_i,
    input  logic rd_ready_i,
    output logic capture_o,
    output logic push_pc_fire_o,
    output logic push_sr_fire_o,
    output logic load_sp_fire_o,
    output logic load_pc_fire_o,
    output logic wr_valid_o,
    output logic wr_long_o,
    output logic rd_valid_o,
    output logic rd_zero_o,
    output logic busy_o,
    output logic done_o
);

    exc_state_e state_q, state_d;
    logic       is_rst_q;

    // Decode the handshake strobes and port requests from the state.
    always_comb begin
        capture_o      = (state_q == ST_IDLE) && start_i;
        wr_valid_o     = (state_q == ST_PUSH_PC) || (state_q == ST_PUSH_SR);
        wr_long_o      = (state_q == ST_PUSH_PC);
        rd_valid_o     = (state_q == ST_LOAD_SP) || (state_q == ST_LOAD_PC);
        rd_zero_o      = (state_q == ST_LOAD_SP);
        push_pc_fire_o = (state_q == ST_PUSH_PC) && wr_ready_i;
        push_sr_fire_o = (state_q == ST_PUSH_SR) && wr_ready_i;
        load_sp_fire_o = (state_q == ST_LOAD_SP) && rd_ready_i;
        load_pc_fire_o = (state_q == ST_LOAD_PC) && rd_ready_i;
        busy_o         = (state_q != ST_IDLE);
        done_o         = (state_q == ST_FINISH);
    end

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start_i) state_d = reset_entry_i ? ST_LOAD_SP : ST_PUSH_PC;
            ST_PUSH_PC: if (wr_ready_i) state_d = ST_PUSH_SR;
            ST_PUSH_SR: if (wr_ready_i) state_d = ST_LOAD_PC;
            ST_LOAD_SP: if (rd_ready_i) state_d = ST_LOAD_PC;
            ST_LOAD_PC: if (rd_ready_i) state_d = ST_FINISH;
            ST_FINISH:  state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // State and entry-kind registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            is_rst_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (capture_o) begin
                is_rst_q <= reset_entry_i;
            end
        end
    end

    a_r10_one_port: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_valid_o && rd_valid_o));

    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && !busy_o));

    a_r6_reset_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && is_rst_q) |-> !wr_valid_o);

    a_r8_busy_no_capture: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !capture_o);

endmodule

// File: rtl/exc_entry_seq.sv
// Exception entry sequencer top. It holds the program counter and the
// latched vector address, steers the write and read ports, and wires
// the status unit, the stack pointer and the state machine together.
// Assumes AW > VEC_W + 2 and that memory returns a longword per read.
module exc_entry_seq
    import exc_pkg::*;
#(
    parameter int AW    = 32,
    parameter int VEC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             reset_entry_i,
    input  logic [VEC_W-1:0] vec_num_i,
    input  logic [AW-1:0]    pc_i,
    input  logic [SR_W-1:0]  sr_i,
    input  logic [AW-1:0]    ssp_i,
    output logic             wr_valid_o,
    input  logic             wr_ready_i,
    output logic [AW-1:0]    wr_addr_o,
    output logic [AW-1:0]    wr_data_o,
    output logic             wr_long_o,
    output logic             rd_valid_o,
    input  logic             rd_ready_i,
    output logic [AW-1:0]    rd_addr_o,
    input  logic [AW-1:0]    rd_data_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [AW-1:0]    pc_o,
    output logic [SR_W-1:0]  sr_o,
    output logic [AW-1:0]    ssp_o
);

    localparam int VEC_PAD = AW - VEC_W - 2;

    logic            capture;
    logic            push_pc_fire, push_sr_fire, load_sp_fire, load_pc_fire;
    logic            rd_zero;
    logic [SR_W-1:0] sr_copy;
    logic [AW-1:0]   sp_minus_long, sp_minus_word;
    logic [AW-1:0]   sp_load_val;
    logic [AW-1:0]   pc_q, vaddr_q, vaddr_d;

    exc_fsm u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .start_i        (start_i),
        .reset_entry_i  (reset_entry_i),
        .wr_ready_i     (wr_ready_i),
        .rd_ready_i     (rd_ready_i),
        .capture_o      (capture),
        .push_pc_fire_o (push_pc_fire),
        .push_sr_fire_o (push_sr_fire),
        .load_sp_fire_o (load_sp_fire),
        .load_pc_fire_o (load_pc_fire),
        .wr_valid_o     (wr_valid_o),
        .wr_long_o      (wr_long_o),
        .rd_valid_o     (rd_valid_o),
        .rd_zero_o      (rd_zero),
        .busy_o         (busy_o),
        .done_o         (done_o)
    );

    exc_status_ctl u_status (
        .clk           (clk),
        .rst_n         (rst_n),
        .capture_i     (capture),
        .reset_entry_i (reset_entry_i),
        .sr_i          (sr_i),
        .sr_copy_o     (sr_copy),
        .sr_live_o     (sr_o)
    );

    // Stack pointer load source: context at start, memory for reset.
    always_comb begin
        sp_load_val = capture ? ssp_i : rd_data_i;
    end

    exc_stack_ptr #(.AW(AW)) u_sp (
        .clk             (clk),
        .rst_n           (rst_n),
        .load_i          (capture || load_sp_fire),
        .load_val_i      (sp_load_val),
        .step_long_i     (push_pc_fire),
        .step_word_i     (push_sr_fire),
        .sp_o            (ssp_o),
        .sp_minus_long_o (sp_minus_long),
        .sp_minus_word_o (sp_minus_word)
    );

    // Vector table address: second reset slot, or vector number times four.
    always_comb begin
        if (reset_entry_i) begin
            vaddr_d = AW'(RESET_PC_AT);
        end else begin
            vaddr_d = {{VEC_PAD{1'b0}}, vec_num_i, 2'b00};
        end
    end

    // Program counter and vector address registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q    <= '0;
            vaddr_q <= '0;
        end else if (capture) begin
            pc_q    <= pc_i;
            vaddr_q <= vaddr_d;
        end else if (load_pc_fire) begin
            pc_q    <= rd_data_i;
        end
    end

    // Port steering for pushes and table reads.
    always_comb begin
        wr_addr_o = wr_long_o ? sp_minus_long : sp_minus_word;
        wr_data_o = wr_long_o ? pc_q : {{(AW-SR_W){1'b0}}, sr_copy};
        rd_addr_o = rd_zero ? '0 : vaddr_q;
        pc_o      = pc_q;
    end

    a_r9_write_held: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid_o && !wr_ready_i) |=>
            (wr_valid_o && $stable(wr_addr_o) && $stable(wr_data_o) && $stable(wr_long_o)));

    a_r9_read_held: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid_o && !rd_ready_i) |=> (rd_valid_o && $stable(rd_addr_o)));

    a_r5_pc_from_table: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid_o && rd_ready_i && !rd_zero) |=> (pc_o == $past(rd_data_i)));

endmodule

// File: tb/exc_entry_seq_tb_top.sv
module exc_entry_seq_tb_top;

    localparam int AW    = 32;
    localparam int VEC_W = 8;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             start_i, reset_entry_i;
    logic [VEC_W-1:0] vec_num_i;
    logic [AW-1:0]    pc_i, ssp_i, rd_data_i;
    logic [15:0]      sr_i;
    logic             wr_ready_i, rd_ready_i;
    logic             wr_valid_o, wr_long_o, rd_valid_o, busy_o, done_o;
    logic [AW-1:0]    wr_addr_o, wr_data_o, rd_addr_o, pc_o, ssp_o;
    logic [15:0]      sr_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    logic [31:0] wlog_addr [0:3];
    logic [31:0] wlog_data [0:3];
    logic        wlog_long [0:3];
    logic [31:0] rlog_addr [0:3];
    int          wcount, rcount;

    always #5 clk = ~clk;

    exc_entry_seq #(.AW(AW), .VEC_W(VEC_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .reset_entry_i(reset_entry_i),
        .vec_num_i(vec_num_i), .pc_i(pc_i), .sr_i(sr_i), .ssp_i(ssp_i),
        .wr_valid_o(wr_valid_o), .wr_ready_i(wr_ready_i), .wr_addr_o(wr_addr_o),
        .wr_data_o(wr_data_o), .wr_long_o(wr_long_o), .rd_valid_o(rd_valid_o),
        .rd_ready_i(rd_ready_i), .rd_addr_o(rd_addr_o), .rd_data_i(rd_data_i),
        .busy_o(busy_o), .done_o(done_o), .pc_o(pc_o), .sr_o(sr_o), .ssp_o(ssp_o)
    );

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        return {a[15:0] ^ 16'h5A3C, a[15:0] + 16'h1357};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_entry(input logic [7:0] vec, input bit rst_e, input logic [31:0] pc,
                             input logic [15:0] sr, input logic [31:0] ssp, input int dly,
                             input bit hold);
        int wt = 0;
        int guard = 0;
        logic [15:0] exp_sr;
        @(negedge clk);
        start_i = 1'b1; reset_entry_i = rst_e; vec_num_i = vec;
        pc_i = pc; sr_i = sr; ssp_i = ssp;
        @(negedge clk);
        if (hold) begin
            vec_num_i = ~vec; pc_i = ~pc; sr_i = ~sr; ssp_i = ssp + 32'd100;
            reset_entry_i = !rst_e;
        end else begin
            start_i = 1'b0;
        end
        wcount = 0; rcount = 0;
        while (!done_o && guard < 60) begin
            wr_ready_i = 1'b0; rd_ready_i = 1'b0;
            chk(!(wr_valid_o && rd_valid_o), "R10", {30'd0, wr_valid_o, rd_valid_o}, 32'd0);
            if (wr_valid_o) begin
                if (wt == dly) begin
                    wr_ready_i = 1'b1;
                    if (wcount < 4) begin
                        wlog_addr[wcount] = wr_addr_o;
                        wlog_data[wcount] = wr_data_o;
                        wlog_long[wcount] = wr_long_o;
                    end
                    wcount++; wt = 0;
                end else wt++;
            end else if (rd_valid_o) begin
                if (wt == dly) begin
                    rd_ready_i = 1'b1;
                    rd_data_i = mem_word(rd_addr_o);
                    if (rcount < 4) rlog_addr[rcount] = rd_addr_o;
                    rcount++; wt = 0;
                end else wt++;
            end
            guard++;
            @(negedge clk);
        end
        wr_ready_i = 1'b0; rd_ready_i = 1'b0; start_i = 1'b0;
        chk(done_o, "R7 done reached", {31'd0, done_o}, 32'd1);
        if (rst_e) begin
            exp_sr = (sr | 16'h2700) & 16'h7FFF;
            chk(wcount == 0, "R6 no writes", wcount, 0);
            chk(rcount == 2, "R6 two reads", rcount, 2);
            if (rcount == 2) begin
                chk(rlog_addr[0] == 0, "R6 first read at 0", rlog_addr[0], 0);
                chk(rlog_addr[1] == 4, "R6 second read at 4", rlog_addr[1], 4);
            end
            chk(ssp_o == mem_word(0), "R6 ssp", ssp_o, mem_word(0));
            chk(pc_o == mem_word(4), "R6 pc", pc_o, mem_word(4));
            chk(sr_o == exp_sr, "R6 status", {16'd0, sr_o}, {16'd0, exp_sr});
        end else begin
            exp_sr = (sr | 16'h2000) & 16'h7FFF;
            chk(sr_o == exp_sr, hold ? "R8 status" : "R2 status", {16'd0, sr_o}, {16'd0, exp_sr});
            chk(wcount == 2, "R3 two writes", wcount, 2);
            if (wcount == 2) begin
                chk(wlog_addr[0] == ssp - 32'd4, "R3 pc push addr", wlog_addr[0], ssp - 32'd4);
                chk(wlog_data[0] == pc, hold ? "R8 pc push data" : "R3 pc push data", wlog_data[0], pc);
                chk(wlog_long[0] == 1'b1, "R3 pc push size", {31'd0, wlog_long[0]}, 32'd1);
                chk(wlog_addr[1] == ssp - 32'd6, "R4 sr push addr", wlog_addr[1], ssp - 32'd6);
                chk(wlog_data[1] == {16'd0, sr}, "R4 sr push data", wlog_data[1], {16'd0, sr});
                chk(wlog_long[1] == 1'b0, "R4 sr push size", {31'd0, wlog_long[1]}, 32'd0);
            end
            chk(ssp_o == ssp - 32'd6, "R4 final ssp", ssp_o, ssp - 32'd6);
            chk(rcount == 1, "R5 one read", rcount, 1);
            if (rcount == 1)
                chk(rlog_addr[0] == {22'd0, vec, 2'b00}, "R5 table addr", rlog_addr[0], {22'd0, vec, 2'b00});
            chk(pc_o == mem_word({22'd0, vec, 2'b00}), hold ? "R8 new pc" : "R5 new pc",
                pc_o, mem_word({22'd0, vec, 2'b00}));
        end
        @(negedge clk);
        chk(!done_o && !busy_o, "R7 pulse ends", {30'd0, done_o, busy_o}, 32'd0);
        chk(!wr_valid_o && !rd_valid_o, "R10 idle ports", {30'd0, wr_valid_o, rd_valid_o}, 32'd0);
    endtask

    initial begin
        rst_n = 1'b0; start_i = 1'b0; reset_entry_i = 1'b0; vec_num_i = '0;
        pc_i = '0; sr_i = '0; ssp_i = '0; rd_data_i = '0;
        wr_ready_i = 1'b0; rd_ready_i = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        chk(!busy_o && !done_o && !wr_valid_o && !rd_valid_o, "R1 reset state",
            {28'd0, busy_o, done_o, wr_valid_o, rd_valid_o}, 32'd0);
        for (int v = 2; v < 256; v++) begin
            logic [31:0] pcv = 32'(v) * 32'h01010101 + 32'h100;
            logic [15:0] srv = 16'(v * 16'h0123) ^ 16'hC0F0;
            logic [31:0] spv = 32'h8000 + 32'(v) * 32'd16;
            run_entry(8'(v), 1'b0, pcv, srv, spv, v % 4, (v % 5) == 0);
        end
        for (int d = 0; d < 8; d++) begin
            run_entry(8'(d + 3), 1'b1, 32'hDEAD0000 + 32'(d), (d % 2 == 1) ? 16'hFFFF : 16'h0000,
                      32'h4000, d % 4, d >= 4);
        end
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule